// File: doc/BRIEF.md
# AC Half-Cycle Polarity Detector and Gate Steering

This block sits between the input-voltage samplers of a bridgeless totem-pole boost rectifier and its four gate drivers. On every strobed sample it subtracts the neutral reading from the line reading to get the signed AC input. It classifies that value against a symmetric dead band. A new half-cycle polarity is accepted only after a run of consecutive qualifying samples.

Once a polarity is in force, the block steers an externally generated complementary PWM pair to the two fast switches. The duty-carrying signal goes to whichever fast switch boosts in that half cycle, and its complement goes to the other fast switch. The two slow leg switches are held in a static pattern for the whole half cycle. Each accepted polarity change first turns off all four gates for a programmable number of samples, then applies the new steering. Out of reset nothing is driven until the first polarity has been confirmed.

Top module: `acpol_steer`

## Requirements
- R1: The AC input is formed as line_code minus neut_code, both treated as unsigned codes, so only the difference matters and not the common level of the two codes.
- R2: After reset all four gate outputs are 0 and pol_valid is 0. Both stay that way until the first polarity has been confirmed and applied.
- R3: While the applied polarity is positive (pol_pos=1), gate_fast_lo follows pwm_duty, gate_fast_hi follows pwm_comp, gate_slow_pos is 1 and gate_slow_neg is 0.
- R4: While the applied polarity is negative (pol_pos=0, pol_valid=1), gate_fast_hi follows pwm_duty, gate_fast_lo follows pwm_comp, gate_slow_neg is 1 and gate_slow_pos is 0.
- R5: A sample counts toward positive only if the difference is strictly greater than hyst_thr, and toward negative only if it is strictly less than minus hyst_thr. Any other sample counts toward neither and clears a run in progress.
- R6: A polarity different from the applied one (or either polarity while none is applied) is confirmed on the confirm_n-th consecutive qualifying sample. A confirm_n of 0 behaves as 1.
- R7: On confirmation all four gates go to 0 for the next blank_n strobed samples. The new steering takes effect at the end of the last of these samples. With blank_n=0 it takes effect at once.
- R8: pol_pos and pol_valid change only when a new polarity is applied. pol_valid never returns to 0 before the next reset.
- R9: Clock cycles with smp_vld=0 change no state, whatever the codes are.
- R10: Samples received during the blanking interval do not count toward any further polarity change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe; codes are taken when 1 |
| line_code | input | SAMPLE_W | Unsigned line-voltage code |
| neut_code | input | SAMPLE_W | Unsigned neutral-voltage code |
| hyst_thr | input | SAMPLE_W | Dead-band half width in codes |
| confirm_n | input | CNT_W | Consecutive samples required to confirm |
| blank_n | input | BLANK_W | Samples with all gates off at a change |
| pwm_duty | input | 1 | Duty-controlled PWM signal |
| pwm_comp | input | 1 | Complement PWM signal |
| gate_fast_hi | output | 1 | High-side fast switch gate |
| gate_fast_lo | output | 1 | Low-side fast switch gate |
| gate_slow_pos | output | 1 | Slow switch held on in the positive half cycle |
| gate_slow_neg | output | 1 | Slow switch held on in the negative half cycle |
| pol_pos | output | 1 | Applied polarity, 1 = positive |
| pol_valid | output | 1 | A polarity has been applied since reset |

## Verification
A wrong run counter or wrong dead-band comparison makes the change arrive one or more samples early or late. The per-cycle model sees this on the gate outputs in the first cycle after the sample where the two disagree. A wrong blanking count keeps gates off for too long or releases them too early, which is visible after the same sample. Swapped steering shows up as soon as pwm_duty and pwm_comp differ, because the bench drives them as independent patterns rather than strict complements.

// File: rtl/acpol_pkg.sv
package acpol_pkg;
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_POS  = 2'd1,
        CLS_NEG  = 2'd2
    } cls_e;

    typedef enum logic [1:0] {
        ST_UNDEF = 2'd0,
        ST_BLANK = 2'd1,
        ST_RUN   = 2'd2
    } seq_e;
endpackage

// File: rtl/acpol_diff.sv
module acpol_diff
    import acpol_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0] line_code,
    input  logic [SAMPLE_W-1:0] neut_code,
    input  logic [SAMPLE_W-1:0] hyst_thr,
    output cls_e                cls
);
    localparam int DW = SAMPLE_W + 1;

    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] thr_pos;
    logic signed [DW-1:0] thr_neg;

    always_comb begin
        diff    = $signed({1'b0, line_code}) - $signed({1'b0, neut_code});
        thr_pos = $signed({1'b0, hyst_thr});
        thr_neg = -thr_pos;
        if (diff > thr_pos)      cls = CLS_POS;
        else if (diff < thr_neg) cls = CLS_NEG;
        else                     cls = CLS_NONE;
    end
endmodule

// File: rtl/acpol_confirm.sv
module acpol_confirm
    import acpol_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             hold,
    input  logic             known,
    input  logic             cur_pol,
    input  cls_e             cls,
    input  logic [CNT_W-1:0] confirm_n,
    output logic             confirm,
    output logic             new_pol
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
    } run_t;

    run_t             run_d, run_q;
    logic [CNT_W:0]   need;
    logic [CNT_W:0]   nxt;
    logic             sdir;
    logic             opp;

    always_comb begin
        run_d   = run_q;
        confirm = 1'b0;
        new_pol = run_q.dir;
        need    = (confirm_n == '0) ? (CNT_W+1)'(1) : {1'b0, confirm_n};
        sdir    = (cls == CLS_POS);
        opp     = (cls != CLS_NONE) && (!known || (sdir != cur_pol));
        nxt     = (CNT_W+1)'(1);
        if (smp_vld) begin
            if (hold) begin
                run_d.cnt = '0;
            end else if (opp) begin
                if ((run_q.cnt != '0) && (run_q.dir == sdir))
                    nxt = {1'b0, run_q.cnt} + (CNT_W+1)'(1);
                run_d.dir = sdir;
                if (nxt >= need) begin
                    confirm   = 1'b1;
                    new_pol   = sdir;
                    run_d.cnt = '0;
                end else begin
                    run_d.cnt = nxt[CNT_W-1:0];
                end
            end else begin
                run_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/acpol_seq.sv
module acpol_seq
    import acpol_pkg::*;
#(
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_vld,
    input  logic               confirm,
    input  logic               new_pol,
    input  logic [BLANK_W-1:0] blank_n,
    output logic               run,
    output logic               hold,
    output logic               known,
    output logic               pol_pos,
    output logic               pol_valid
);
    typedef struct packed {
        seq_e               st;
        logic               pol;
        logic               pend;
        logic [BLANK_W-1:0] bcnt;
        logic               valid;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (smp_vld) begin
            if (seq_q.st == ST_BLANK) begin
                if (seq_q.bcnt <= BLANK_W'(1)) begin
                    seq_d.st    = ST_RUN;
                    seq_d.pol   = seq_q.pend;
                    seq_d.valid = 1'b1;
                    seq_d.bcnt  = '0;
                end else begin
                    seq_d.bcnt = seq_q.bcnt - BLANK_W'(1);
                end
            end else if (confirm) begin
                if (blank_n == '0) begin
                    seq_d.st    = ST_RUN;
                    seq_d.pol   = new_pol;
                    seq_d.valid = 1'b1;
                end else begin
                    seq_d.st   = ST_BLANK;
                    seq_d.pend = new_pol;
                    seq_d.bcnt = blank_n;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= ST_UNDEF;
            seq_q.pol   <= 1'b0;
            seq_q.pend  <= 1'b0;
            seq_q.bcnt  <= '0;
            seq_q.valid <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run       = (seq_q.st == ST_RUN);
    assign hold      = (seq_q.st == ST_BLANK);
    assign known     = (seq_q.st == ST_RUN);
    assign pol_pos   = seq_q.pol;
    assign pol_valid = seq_q.valid;
endmodule

// File: rtl/acpol_route.sv
module acpol_route (
    input  logic run,
    input  logic pol,
    input  logic pwm_duty,
    input  logic pwm_comp,
    output logic gate_fast_hi,
    output logic gate_fast_lo,
    output logic gate_slow_pos,
    output logic gate_slow_neg
);
    always_comb begin
        gate_fast_hi  = 1'b0;
        gate_fast_lo  = 1'b0;
        gate_slow_pos = 1'b0;
        gate_slow_neg = 1'b0;
        if (run) begin
            if (pol) begin
                gate_fast_lo  = pwm_duty;
                gate_fast_hi  = pwm_comp;
                gate_slow_pos = 1'b1;
            end else begin
                gate_fast_hi  = pwm_duty;
                gate_fast_lo  = pwm_comp;
                gate_slow_neg = 1'b1;
            end
        end
    end
endmodule

// File: rtl/acpol_steer.sv
module acpol_steer
    import acpol_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 8,
    parameter int BLANK_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] line_code,
    input  logic [SAMPLE_W-1:0] neut_code,
    input  logic [SAMPLE_W-1:0] hyst_thr,
    input  logic [CNT_W-1:0]    confirm_n,
    input  logic [BLANK_W-1:0]  blank_n,
    input  logic                pwm_duty,
    input  logic                pwm_comp,
    output logic                gate_fast_hi,
    output logic                gate_fast_lo,
    output logic                gate_slow_pos,
    output logic                gate_slow_neg,
    output logic                pol_pos,
    output logic                pol_valid
);
    cls_e cls;
    logic confirm, new_pol, run, hold, known;

    acpol_diff #(.SAMPLE_W(SAMPLE_W)) u_diff (
        .line_code(line_code), .neut_code(neut_code),
        .hyst_thr(hyst_thr), .cls(cls)
    );

    acpol_confirm #(.CNT_W(CNT_W)) u_confirm (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .hold(hold),
        .known(known), .cur_pol(pol_pos), .cls(cls),
        .confirm_n(confirm_n), .confirm(confirm), .new_pol(new_pol)
    );

    acpol_seq #(.BLANK_W(BLANK_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .confirm(confirm),
        .new_pol(new_pol), .blank_n(blank_n), .run(run), .hold(hold),
        .known(known), .pol_pos(pol_pos), .pol_valid(pol_valid)
    );

    acpol_route u_route (
        .run(run), .pol(pol_pos), .pwm_duty(pwm_duty), .pwm_comp(pwm_comp),
        .gate_fast_hi(gate_fast_hi), .gate_fast_lo(gate_fast_lo),
        .gate_slow_pos(gate_slow_pos), .gate_slow_neg(gate_slow_neg)
    );
endmodule

// File: rtl/acpol_steer_chk.sv
module acpol_steer_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_vld,
    input logic pwm_duty,
    input logic pwm_comp,
    input logic gate_fast_hi,
    input logic gate_fast_lo,
    input logic gate_slow_pos,
    input logic gate_slow_neg,
    input logic pol_pos,
    input logic pol_valid
);
    p_idle_gates_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_valid |-> !(gate_fast_hi || gate_fast_lo || gate_slow_pos || gate_slow_neg));

    p_slow_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_slow_pos && gate_slow_neg));

    p_pos_steer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_slow_pos |-> (pol_pos && pol_valid && gate_fast_lo == pwm_duty && gate_fast_hi == pwm_comp));

    p_neg_steer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_slow_neg |-> (!pol_pos && pol_valid && gate_fast_hi == pwm_duty && gate_fast_lo == pwm_comp));

    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pol_valid |=> pol_valid);

    p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(pol_pos) && $stable(pol_valid)));
endmodule

bind acpol_steer acpol_steer_chk u_chk (.*);

// File: tb/acpol_steer_tb.sv
`timescale 1ns/1ps
module acpol_steer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] line_code = '0, neut_code = '0, hyst_thr = 12'd100;
    logic [7:0]  confirm_n = 8'd3, blank_n = 8'd2;
    logic        pwm_duty = 1'b0, pwm_comp = 1'b0;
    logic        gate_fast_hi, gate_fast_lo, gate_slow_pos, gate_slow_neg, pol_pos, pol_valid;

    int n_chk = 0, n_fail = 0, cyc = 0;
    // behavioural model: 0 none applied, 1 blanking, 2 running
    int m_st = 0, m_pol = 0, m_pend = 0, m_run = 0, m_dir = 0, m_bl = 0, m_valid = 0;

    always #2 clk = ~clk;

    acpol_steer u_dut (.*);

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_pol = 0; m_pend = 0; m_run = 0; m_dir = 0; m_bl = 0; m_valid = 0;
        end else if (smp_vld) begin
            int d, c, need;
            d = int'(line_code) - int'(neut_code);
            c = (d > int'(hyst_thr)) ? 1 : ((d < -int'(hyst_thr)) ? -1 : 0);
            need = (confirm_n == 0) ? 1 : int'(confirm_n);
            if (m_st == 1) begin
                m_run = 0;
                if (m_bl <= 1) begin m_st = 2; m_pol = m_pend; m_valid = 1; end
                else m_bl--;
            end else if (c != 0 && (m_st == 0 || ((c > 0) ? 1 : 0) != m_pol)) begin
                if (m_run > 0 && m_dir == ((c > 0) ? 1 : 0)) m_run++;
                else m_run = 1;
                m_dir = (c > 0) ? 1 : 0;
                if (m_run >= need) begin
                    m_run = 0;
                    if (blank_n == 0) begin m_st = 2; m_pol = m_dir; m_valid = 1; end
                    else begin m_st = 1; m_pend = m_dir; m_bl = int'(blank_n); end
                end
            end else begin
                m_run = 0;
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        #1;
        begin
            string tg;
            int on;
            on = (m_st == 2);
            tg = (m_st == 0) ? "R2" : (m_st == 1) ? "R7" : (m_pol != 0) ? "R3" : "R4";
            check(tg, gate_slow_pos, on & m_pol);
            check(tg, gate_slow_neg, on & (1 - m_pol));
            check(tg, gate_fast_lo, on ? (m_pol != 0 ? int'(pwm_duty) : int'(pwm_comp)) : 0);
            check(tg, gate_fast_hi, on ? (m_pol != 0 ? int'(pwm_comp) : int'(pwm_duty)) : 0);
            check("R8", pol_valid, m_valid);
            if (m_valid != 0) check("R8", pol_pos, m_pol);
        end
    end

    // PWM inputs: independent patterns so that swapped routing is visible
    always @(negedge clk) begin
        pwm_duty <= cyc[0] ^ cyc[2];
        pwm_comp <= cyc[1];
    end

    task automatic smp(int ln, int nt);
        @(negedge clk);
        smp_vld = 1'b1; line_code = 12'(ln); neut_code = 12'(nt);
        @(negedge clk);
        smp_vld = 1'b0; line_code = 12'(nt); neut_code = 12'(ln);
        #1;
    endtask

    task automatic expect_state(string req, int valid, int pos);
        check(req, pol_valid, valid);
        if (valid != 0) check(req, pol_pos, pos);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check("R2", gate_slow_pos | gate_slow_neg | gate_fast_hi | gate_fast_lo, 0);
        check("R2", pol_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        // R9: strobe low, large difference on the codes
        line_code = 12'd4000; neut_code = 12'd10;
        repeat (10) @(negedge clk);
        #1; expect_state("R9", 0, 0);
        // R5 and R1: small differences at low and high common levels
        repeat (3) smp(2000, 1950);
        repeat (3) smp(4000, 3950);
        smp(3000, 2900);
        expect_state("R1", 0, 0);
        expect_state("R5", 0, 0);
        // R6: run broken by a dead-band sample
        smp(2500, 2000); smp(2500, 2000); smp(2050, 2000);
        smp(2500, 2000); smp(2500, 2000);
        expect_state("R6", 0, 0);
        smp(2500, 2000);                 // third consecutive -> blanking
        expect_state("R7", 0, 0);
        smp(1000, 1600);                 // blank sample 1, negative
        expect_state("R7", 0, 0);
        smp(1000, 1600);                 // blank sample 2, applies positive
        expect_state("R8", 1, 1);
        check("R3", gate_slow_pos, 1);
        // R10: blanked negatives did not count
        smp(1000, 1600); smp(1000, 1600);
        expect_state("R10", 1, 1);
        // R9: idle gaps do not break a run
        repeat (5) @(negedge clk);
        smp(1000, 1600);                 // third -> blanking
        check("R7", gate_slow_pos | gate_slow_neg | gate_fast_hi | gate_fast_lo, 0);
        smp(2000, 2000); smp(2000, 2000);
        expect_state("R4", 1, 0);
        check("R4", gate_slow_neg, 1);
        repeat (8) @(negedge clk);
        // immediate mode, R6 with zero count, R5 boundary
        confirm_n = 8'd0; blank_n = 8'd0;
        smp(1100, 1000);                 // exactly threshold
        expect_state("R5", 1, 0);
        smp(1101, 1000);                 // one above -> immediate
        expect_state("R6", 1, 1);
        check("R7", gate_slow_pos, 1);
        smp(1000, 1100);                 // exactly minus threshold
        expect_state("R5", 1, 1);
        smp(0, 4095);
        expect_state("R1", 1, 0);
        // extremes of the code range
        smp(4095, 0);
        expect_state("R1", 1, 1);
        repeat (6) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule